// File: doc/BRIEF.md
# Dual-Class Shared-Bus Access Arbiter

This block keeps two classes of users away from each other on one power-management-IC bus. The first class is the local bus masters and the second is the requesters of the power-management agent. Within a class, any number of grants may be open at the same time, up to the counter limit. Each class keeps a reference count of its open grants, and a class may be granted only while the other class's count is zero.

The local class also drives a hardware semaphore sequence. When the local count is zero, an acquire asks the external semaphore sequencer for the bus and is answered only when that sequence finishes. If the local count is already above zero, an acquire is a plain increment. The local release that empties the count tells the sequencer to drop the semaphore.

Each request is a level that stays high until a one-cycle acknowledge arrives. A result bit sent with the acknowledge says whether the grant was given. Sticky error flags record three cases: a release with nothing held, an acquire refused at the limit, and an agent-only operation attempted with no agent grant open.

Top module: `shbus_arbiter`

## Requirements
- R1: While reset is high and in the first cycle after it, both counts are 0, and all acknowledges, result bits, stalls, sequencer strobes and error flags are 0.
- R2: An agent request that is seen while the local count is 0 and no semaphore sequence is in flight gets agt_ack high in the next cycle. If the agent count was below its maximum, agt_ok is 1 and the agent count rises by 1. Any other agent request leaves agt_count unchanged and shows agt_stall high from the next cycle onwards.
- R3: A local request is not served while the agent count is nonzero. loc_stall is high and loc_count stays 0. The two counts are never both nonzero.
- R4: A local request seen with the local count at 0 gives a one-cycle seq_start pulse and no acknowledge until seq_done. In the cycle after seq_done, loc_ack is 1. If seq_ok was 1, loc_ok is 1 and the count becomes 1. If seq_ok was 0, loc_ok is 0, the count stays 0 and seq_release pulses once.
- R5: A local request seen with a local count between 1 and the maximum minus 1 is acknowledged in the next cycle with loc_ok = 1. The count rises by 1 and no seq_start is produced.
- R6: seq_release pulses for one cycle exactly when a local release takes the local count from 1 to 0. It also pulses on a failed sequence (R4). Other releases do not pulse it.
- R7: The agent release that takes the agent count to 0 unblocks a held local request. That request's semaphore sequence then starts without the request being raised again.
- R8: A release on a class whose count is 0 changes no count and no strobe, and sets udf_err. udf_err stays set until reset.
- R9: If both classes request in the same cycle with both counts at 0 and no sequence in flight, the agent class is acknowledged and the local request stalls.
- R10: Counts are CW bits wide, with a maximum of 2^CW-1. An acquire at the maximum is acknowledged with ok = 0, leaves the count at the maximum, and sets the sticky ovf_err flag.
- R11: agt_held is 1 exactly while agt_count is nonzero. agt_chk high in a cycle where the agent count is 0 sets the sticky chk_err flag. agt_chk with the agent count nonzero leaves chk_err unchanged.
- R12: A request is ignored in the cycle its own acknowledge is high, so a requester that drops its request on seeing the acknowledge gets exactly one grant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| loc_req | input | 1 | Local-class acquire request, held until loc_ack |
| loc_rel | input | 1 | Local-class release, one pulse per grant |
| agt_req | input | 1 | Agent-class acquire request, held until agt_ack |
| agt_rel | input | 1 | Agent-class release, one pulse per grant |
| agt_chk | input | 1 | An operation that needs an open agent grant is taking place |
| seq_done | input | 1 | Semaphore sequencer has finished |
| seq_ok | input | 1 | Sequencer result, valid with seq_done (1 = semaphore taken) |
| loc_ack | output | 1 | Local request answered |
| loc_ok | output | 1 | With loc_ack: 1 = granted, 0 = refused |
| loc_stall | output | 1 | Local request held off |
| agt_ack | output | 1 | Agent request answered |
| agt_ok | output | 1 | With agt_ack: 1 = granted, 0 = refused |
| agt_stall | output | 1 | Agent request held off |
| seq_start | output | 1 | One-cycle strobe: take the semaphore |
| seq_release | output | 1 | One-cycle strobe: drop the semaphore |
| agt_held | output | 1 | At least one agent grant is open |
| loc_count | output | CW | Open local grants |
| agt_count | output | CW | Open agent grants |
| udf_err | output | 1 | Sticky: release with count at zero |
| ovf_err | output | 1 | Sticky: acquire refused at the maximum |
| chk_err | output | 1 | Sticky: agent-only operation with no agent grant open |

## Verification
The hardest states to reach are the counter limits and the hand-over between classes while a request is waiting. The bench reaches the limit by issuing 255 back-to-back agent acquires and then one more. It reaches the hand-over by holding a local request high across the agent class's last release, and then holding an agent request high across the local class's last release. A behavioural sequencer answers each seq_start after a set latency and can be told to fail, which drives the path where the semaphore is reset on failure. Same-cycle requests from both classes with both counts empty exercise the tie rule. A cycle-accurate reference model checks every output on every clock.

// File: rtl/shbus_pkg.sv
package shbus_pkg;
  typedef enum logic {
    LS_IDLE = 1'b0,
    LS_BUSY = 1'b1
  } lseq_e;
endpackage

// File: rtl/shbus_refcnt.sv
module shbus_refcnt #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          inc,
  input  logic          dec,
  output logic [CW-1:0] cnt,
  output logic          zero,
  output logic          full
);
  localparam logic [CW-1:0] CMAX = '1;

  logic up, dn;
  assign zero = (cnt == '0);
  assign full = (cnt == CMAX);
  assign up   = inc & ~full;
  assign dn   = dec & ~zero;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else begin
      case ({up, dn})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  // R10: the count never wraps from the top
  p_no_wrap_top_r10: assert property (@(posedge clk) disable iff (rst)
    (cnt == CMAX && !dec) |=> (cnt == CMAX));
  // R8: the count never wraps from the bottom
  p_no_wrap_bot_r8: assert property (@(posedge clk) disable iff (rst)
    (cnt == '0 && !inc) |=> (cnt == '0));
endmodule

// File: rtl/shbus_lseq.sv
module shbus_lseq
  import shbus_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic launch,
  input  logic done,
  input  logic ok,
  output logic busy,
  output logic start,
  output logic fin,
  output logic pass
);
  lseq_e st;

  assign busy = (st == LS_BUSY);
  assign fin  = busy & done;
  assign pass = busy & done & ok;

  always_ff @(posedge clk) begin
    if (rst) begin
      st    <= LS_IDLE;
      start <= 1'b0;
    end else begin
      start <= 1'b0;
      case (st)
        LS_IDLE: if (launch) begin
          st    <= LS_BUSY;
          start <= 1'b1;
        end
        LS_BUSY: if (done) st <= LS_IDLE;
        default: st <= LS_IDLE;
      endcase
    end
  end

  // R4: a new sequence is only launched from idle
  p_launch_idle_r4: assert property (@(posedge clk) disable iff (rst)
    launch |-> !busy);
  // R4: the start strobe lasts one cycle
  p_start_pulse_r4: assert property (@(posedge clk) disable iff (rst)
    start |=> !start);
endmodule

// File: rtl/shbus_arbiter.sv
module shbus_arbiter #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          loc_req,
  input  logic          loc_rel,
  input  logic          agt_req,
  input  logic          agt_rel,
  input  logic          agt_chk,
  input  logic          seq_done,
  input  logic          seq_ok,
  output logic          loc_ack,
  output logic          loc_ok,
  output logic          loc_stall,
  output logic          agt_ack,
  output logic          agt_ok,
  output logic          agt_stall,
  output logic          seq_start,
  output logic          seq_release,
  output logic          agt_held,
  output logic [CW-1:0] loc_count,
  output logic [CW-1:0] agt_count,
  output logic          udf_err,
  output logic          ovf_err,
  output logic          chk_err
);
  localparam logic [CW-1:0] ONE = CW'(1);

  logic loc_zero, loc_full, agt_zero, agt_full;
  logic lbusy, sq_fin, sq_pass;
  logic agt_try, loc_try, agt_go, loc_go;
  logic agt_inc, agt_ref, agt_dec;
  logic loc_launch, loc_dir, loc_ref, loc_inc, loc_dec;
  logic loc_ack_d, loc_ok_d, srel_d;

  always_comb begin
    agt_try    = agt_req & ~agt_ack;
    loc_try    = loc_req & ~loc_ack;
    agt_go     = agt_try & loc_zero & ~lbusy;
    agt_inc    = agt_go & ~agt_full;
    agt_ref    = agt_go & agt_full;
    loc_go     = loc_try & agt_zero & ~lbusy & ~agt_go;
    loc_launch = loc_go & loc_zero;
    loc_dir    = loc_go & ~loc_zero & ~loc_full;
    loc_ref    = loc_go & loc_full;
    loc_inc    = loc_dir | sq_pass;
    loc_dec    = loc_rel & ~loc_zero;
    agt_dec    = agt_rel & ~agt_zero;
    loc_ack_d  = (loc_go & ~loc_zero) | sq_fin;
    loc_ok_d   = loc_dir | sq_pass;
    srel_d     = (loc_dec & (loc_count == ONE) & ~loc_inc) | (sq_fin & ~sq_pass);
  end

  shbus_refcnt #(.CW(CW)) u_loc_cnt (
    .clk(clk), .rst(rst), .inc(loc_inc), .dec(loc_dec),
    .cnt(loc_count), .zero(loc_zero), .full(loc_full)
  );

  shbus_refcnt #(.CW(CW)) u_agt_cnt (
    .clk(clk), .rst(rst), .inc(agt_inc), .dec(agt_dec),
    .cnt(agt_count), .zero(agt_zero), .full(agt_full)
  );

  shbus_lseq u_lseq (
    .clk(clk), .rst(rst), .launch(loc_launch), .done(seq_done), .ok(seq_ok),
    .busy(lbusy), .start(seq_start), .fin(sq_fin), .pass(sq_pass)
  );

  assign agt_held = ~agt_zero;

  always_ff @(posedge clk) begin
    if (rst) begin
      loc_ack     <= 1'b0;
      loc_ok      <= 1'b0;
      loc_stall   <= 1'b0;
      agt_ack     <= 1'b0;
      agt_ok      <= 1'b0;
      agt_stall   <= 1'b0;
      seq_release <= 1'b0;
      udf_err     <= 1'b0;
      ovf_err     <= 1'b0;
      chk_err     <= 1'b0;
    end else begin
      loc_ack     <= loc_ack_d;
      loc_ok      <= loc_ok_d;
      loc_stall   <= loc_req & ~loc_ack & ~loc_ack_d;
      agt_ack     <= agt_go;
      agt_ok      <= agt_inc;
      agt_stall   <= agt_req & ~agt_ack & ~agt_go;
      seq_release <= srel_d;
      if ((loc_rel & loc_zero) | (agt_rel & agt_zero)) udf_err <= 1'b1;
      if (loc_ref | agt_ref)                           ovf_err <= 1'b1;
      if (agt_chk & agt_zero)                          chk_err <= 1'b1;
    end
  end

  // R3: the two classes never hold grants together
  p_mutex_r3: assert property (@(posedge clk) disable iff (rst)
    !(loc_count != '0 && agt_count != '0));
  // R9: same-cycle tie with both counts empty goes to the agent class
  p_tie_agent_r9: assert property (@(posedge clk) disable iff (rst)
    (agt_try && loc_try && loc_zero && agt_zero && !lbusy)
      |=> (agt_ack && !loc_ack && !seq_start));
  // R6: the semaphore is released only with the local count empty
  p_release_empty_r6: assert property (@(posedge clk) disable iff (rst)
    seq_release |-> (loc_count == '0));
  // R8: the underflow flag is sticky
  p_udf_sticky_r8: assert property (@(posedge clk) disable iff (rst)
    udf_err |=> udf_err);
  // R11: the check flag rises only after an unheld agent-only operation
  p_chk_cause_r11: assert property (@(posedge clk) disable iff (rst)
    $rose(chk_err) |-> $past(agt_chk && agt_count == '0));
endmodule

// File: tb/sim_shbus_arbiter.sv
module sim_shbus_arbiter;
  localparam int CW   = 8;
  localparam int TCLK = 10;
  localparam int CMAX = (1 << CW) - 1;

  logic clk = 1'b0, rst = 1'b1;
  logic loc_req = 0, loc_rel = 0, agt_req = 0, agt_rel = 0, agt_chk = 0;
  logic seq_done = 0, seq_ok = 0;
  logic loc_ack, loc_ok, loc_stall, agt_ack, agt_ok, agt_stall;
  logic seq_start, seq_release, agt_held, udf_err, ovf_err, chk_err;
  logic [CW-1:0] loc_count, agt_count;

  always #(TCLK/2) clk = ~clk;

  shbus_arbiter #(.CW(CW)) u0 (
    .clk(clk), .rst(rst), .loc_req(loc_req), .loc_rel(loc_rel),
    .agt_req(agt_req), .agt_rel(agt_rel), .agt_chk(agt_chk),
    .seq_done(seq_done), .seq_ok(seq_ok),
    .loc_ack(loc_ack), .loc_ok(loc_ok), .loc_stall(loc_stall),
    .agt_ack(agt_ack), .agt_ok(agt_ok), .agt_stall(agt_stall),
    .seq_start(seq_start), .seq_release(seq_release), .agt_held(agt_held),
    .loc_count(loc_count), .agt_count(agt_count),
    .udf_err(udf_err), .ovf_err(ovf_err), .chk_err(chk_err)
  );

  int n_chk = 0, n_bad = 0;
  int seq_lat = 3;
  logic seq_pass = 1'b1;
  int n_sst = 0, n_srel = 0;

  task automatic chk(string req, string what, int act, int exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  // behavioural reference model
  int m_lc = 0, m_ac = 0;
  bit m_busy = 0, m_lack = 0, m_lok = 0, m_aack = 0, m_aok = 0;
  bit m_sst = 0, m_srel = 0, m_lst = 0, m_ast = 0;
  bit m_udf = 0, m_ovf = 0, m_chk = 0, m_valid = 0;

  always @(posedge clk) begin : model
    int lc_up, lc_dn, ac_up, ac_dn;
    bit n_lack, n_lok, n_aack, n_aok, n_sst, n_srel, a_go, n_busy;
    m_valid = 1;
    if (rst) begin
      m_lc = 0; m_ac = 0; m_busy = 0; m_lack = 0; m_lok = 0; m_aack = 0;
      m_aok = 0; m_sst = 0; m_srel = 0; m_lst = 0; m_ast = 0;
      m_udf = 0; m_ovf = 0; m_chk = 0;
    end else begin
      lc_up = 0; lc_dn = 0; ac_up = 0; ac_dn = 0;
      n_lack = 0; n_lok = 0; n_aack = 0; n_aok = 0; n_sst = 0; n_srel = 0;
      a_go = 0; n_busy = m_busy;
      if (m_busy && seq_done) begin
        n_busy = 0; n_lack = 1;
        if (seq_ok) begin n_lok = 1; lc_up = 1; end
        else n_srel = 1;
      end
      if (agt_req && !m_aack && m_lc == 0 && !m_busy) begin
        a_go = 1; n_aack = 1;
        if (m_ac == CMAX) m_ovf = 1;
        else begin n_aok = 1; ac_up = 1; end
      end else if (loc_req && !m_lack && m_ac == 0 && !m_busy) begin
        if (m_lc == CMAX) begin n_lack = 1; m_ovf = 1; end
        else if (m_lc > 0) begin n_lack = 1; n_lok = 1; lc_up = 1; end
        else begin n_busy = 1; n_sst = 1; end
      end
      if (loc_rel) begin if (m_lc == 0) m_udf = 1; else lc_dn = 1; end
      if (agt_rel) begin if (m_ac == 0) m_udf = 1; else ac_dn = 1; end
      if (agt_chk && m_ac == 0) m_chk = 1;
      if (lc_dn == 1 && m_lc == 1 && lc_up == 0) n_srel = 1;
      m_ast = agt_req && !m_aack && !a_go;
      m_lst = loc_req && !m_lack && !n_lack;
      m_lc = m_lc + lc_up - lc_dn;
      m_ac = m_ac + ac_up - ac_dn;
      m_busy = n_busy; m_lack = n_lack; m_lok = n_lok; m_aack = n_aack;
      m_aok = n_aok; m_sst = n_sst; m_srel = n_srel;
    end
  end

  always @(negedge clk) begin
    if (seq_start === 1'b1) n_sst++;
    if (seq_release === 1'b1) n_srel++;
    if (m_valid) begin
      chk("R2", "model agt_count", int'(agt_count), m_ac);
      chk("R3", "model loc_count", int'(loc_count), m_lc);
      chk("R5", "model loc_ack", int'(loc_ack), int'(m_lack));
      chk("R5", "model loc_ok", int'(loc_ok), int'(m_lok));
      chk("R2", "model agt_ack", int'(agt_ack), int'(m_aack));
      chk("R2", "model agt_ok", int'(agt_ok), int'(m_aok));
      chk("R3", "model loc_stall", int'(loc_stall), int'(m_lst));
      chk("R2", "model agt_stall", int'(agt_stall), int'(m_ast));
      chk("R4", "model seq_start", int'(seq_start), int'(m_sst));
      chk("R6", "model seq_release", int'(seq_release), int'(m_srel));
      chk("R8", "model udf_err", int'(udf_err), int'(m_udf));
      chk("R10", "model ovf_err", int'(ovf_err), int'(m_ovf));
      chk("R11", "model chk_err", int'(chk_err), int'(m_chk));
      chk("R11", "model agt_held", int'(agt_held), int'(m_ac != 0));
    end
  end

  task automatic seq_responder();
    forever begin
      @(negedge clk);
      seq_done = 1'b0;
      if (seq_start === 1'b1) begin
        repeat (seq_lat - 1) @(negedge clk);
        seq_ok   = seq_pass;
        seq_done = 1'b1;
      end
    end
  endtask

  task automatic acq_agt(output logic ok);
    agt_req = 1'b1;
    do @(negedge clk); while (agt_ack !== 1'b1);
    ok = agt_ok;
    agt_req = 1'b0;
  endtask

  task automatic acq_loc(output logic ok);
    loc_req = 1'b1;
    do @(negedge clk); while (loc_ack !== 1'b1);
    ok = loc_ok;
    loc_req = 1'b0;
  endtask

  task automatic rel_agt();
    agt_rel = 1'b1; @(negedge clk); agt_rel = 1'b0;
  endtask

  task automatic rel_loc();
    loc_rel = 1'b1; @(negedge clk); loc_rel = 1'b0;
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: run did not complete");
    finish_run();
  end

  initial begin
    logic ok;
    int s, r;
    fork seq_responder(); join_none
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1", "reset loc_count", int'(loc_count), 0);
    chk("R1", "reset agt_count", int'(agt_count), 0);
    chk("R1", "reset flags", int'({udf_err, ovf_err, chk_err, seq_start, seq_release}), 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1", "post-reset acks", int'({loc_ack, agt_ack, loc_stall, agt_stall}), 0);

    // R2 / R12: two nested agent grants, one grant per acknowledge
    acq_agt(ok); chk("R2", "agt ok 1", int'(ok), 1);
    acq_agt(ok); chk("R12", "agt ok 2", int'(ok), 1);
    @(negedge clk);
    chk("R12", "agt_count after two", int'(agt_count), 2);
    chk("R11", "agt_held", int'(agt_held), 1);

    // R3 then R7: local held off, released by the last agent release
    s = n_sst;
    loc_req = 1'b1;
    repeat (3) @(negedge clk);
    #1;
    chk("R3", "loc_stall while agent held", int'(loc_stall), 1);
    chk("R3", "loc_count while agent held", int'(loc_count), 0);
    chk("R3", "no seq_start while blocked", n_sst, s);
    rel_agt(); rel_agt();
    do @(negedge clk); while (loc_ack !== 1'b1);
    loc_req = 1'b0;
    #1;
    chk("R7", "local granted after agent drains", int'(loc_ok), 1);
    chk("R4", "one sequence started", n_sst, s + 1);
    chk("R4", "loc_count after sequence", int'(loc_count), 1);

    // R5: nested local acquire skips the sequence
    s = n_sst;
    acq_loc(ok); #1;
    chk("R5", "nested ok", int'(ok), 1);
    chk("R5", "no extra seq_start", n_sst, s);
    @(negedge clk);
    chk("R5", "loc_count 2", int'(loc_count), 2);

    // R2: agent held off while local holds; R6 release behaviour
    agt_req = 1'b1;
    repeat (3) @(negedge clk);
    chk("R2", "agt_stall while local held", int'(agt_stall), 1);
    chk("R2", "agt_count while local held", int'(agt_count), 0);
    r = n_srel;
    rel_loc(); #1;
    chk("R6", "no release on 2->1", n_srel, r);
    rel_loc(); #1;
    chk("R6", "release on 1->0", n_srel, r + 1);
    do @(negedge clk); while (agt_ack !== 1'b1);
    agt_req = 1'b0;
    chk("R2", "agent granted after local drains", int'(agt_ok), 1);
    rel_agt();

    // R8: release at zero ignored
    r = n_srel;
    rel_loc(); #1;
    chk("R8", "udf_err set", int'(udf_err), 1);
    chk("R8", "loc_count unchanged", int'(loc_count), 0);
    chk("R8", "no release strobe", n_srel, r);

    // R4: failed sequence
    seq_pass = 1'b0;
    r = n_srel;
    acq_loc(ok); #1;
    chk("R4", "failed sequence ok", int'(ok), 0);
    chk("R4", "failed sequence release", n_srel, r + 1);
    @(negedge clk);
    chk("R4", "loc_count after failure", int'(loc_count), 0);
    seq_pass = 1'b1;

    // R9: tie with both counts empty
    s = n_sst;
    agt_req = 1'b1; loc_req = 1'b1;
    @(negedge clk);
    chk("R9", "agent acked on tie", int'(agt_ack), 1);
    chk("R9", "local not acked on tie", int'(loc_ack), 0);
    chk("R9", "local stalls on tie", int'(loc_stall), 1);
    agt_req = 1'b0;
    rel_agt();
    do @(negedge clk); while (loc_ack !== 1'b1);
    loc_req = 1'b0;
    chk("R9", "local served after agent", int'(loc_ok), 1);
    rel_loc();

    // R10: agent count at the maximum
    for (int i = 0; i < CMAX; i++) acq_agt(ok);
    @(negedge clk);
    chk("R10", "agt_count at max", int'(agt_count), CMAX);
    acq_agt(ok);
    chk("R10", "refused at max", int'(ok), 0);
    @(negedge clk);
    chk("R10", "ovf_err", int'(ovf_err), 1);
    chk("R10", "count held at max", int'(agt_count), CMAX);

    // R11: agent-only operation check
    agt_chk = 1'b1; @(negedge clk); agt_chk = 1'b0;
    chk("R11", "no chk_err while held", int'(chk_err), 0);
    for (int i = 0; i < CMAX; i++) rel_agt();
    chk("R11", "agt_held clear", int'(agt_held), 0);
    agt_chk = 1'b1; @(negedge clk); agt_chk = 1'b0;
    chk("R11", "chk_err set", int'(chk_err), 1);

    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule